// File: doc/BRIEF.md
# Autostore Shadowed RAM Controller

This block holds a byte-wide static RAM. Each RAM bit has a matching bit in a shadow array that keeps its contents through a supply loss. A host reaches the RAM through an SRAM-style interface. It drives an address and three active-low strobes: chip select, output enable and write enable. The data bus is split into an input byte, an output byte and an output-enable flag. A pad ring would merge these three into one bidirectional bus.

Two already-synchronized supply indications control the transfers between the arrays:

- **Supply-good rising:** the block copies the whole shadow array into RAM before it serves any host access.
- **Supply-low warning:** the block copies the whole RAM into the shadow array. This store happens only if the host wrote the RAM since the last power-up or store, and only if output enable is high when the warning arrives.

The store copies one address per step. Each step lasts `CELL_CYCLES` clocks. An elaboration check ensures that the whole store fits inside the program-time limit `STORE_LIMIT`, which is given in clock cycles (2.5 ms at 250 MHz by default).

Top module: `autostore_nvram`

## Requirements
- R1: After reset, with supply-good low, `busy` is low and `data_oe` is low.
- R2: When supply-good is high in the powered-off state, the block recalls every shadow location into RAM. `busy` is high for exactly 2^ADDR_W cycles. Afterwards each RAM byte equals the shadow byte last stored at that address.
- R3: `data_oe` is high only when the block is idle and powered, `ce_n` = 0, `oe_n` = 0 and `we_n` = 1. In that case `data_out` is the RAM byte at `addr`. In every other case `data_oe` is low.
- R4: A write takes place at the clock edge where the block is idle and powered, `ce_n` = 0 and `we_n` = 0. It places `data_in` into RAM at `addr`.
- R5: A rising edge of supply-low starts a store when all of these hold: the block is idle, the RAM is dirty, and `oe_n` = 1. During the store `busy` is high for exactly 2^ADDR_W × CELL_CYCLES cycles, which never exceeds `STORE_LIMIT`.
- R6: If no RAM write has occurred since power-up, a supply-low rising edge starts no store, and `busy` stays low.
- R7: If `oe_n` = 0 at the supply-low rising edge, no store starts.
- R8: While supply-good is low, host reads do not drive the bus and host writes have no effect.
- R9: While `busy` is high, host reads do not drive the bus and host writes do not change RAM.
- R10: A completed store clears the dirty state. A second supply-low rising edge with no write in between starts no store.
- R11: A store that begins runs to completion even if supply-good falls and rises again during it. No recall follows until a later power-up from the off state.
- R12: A recall clears the dirty state, so a supply-low rising edge right after a recall starts no store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of control state (arrays are not reset) |
| pwr_good | input | 1 | Synchronized supply above inhibit level |
| pwr_low | input | 1 | Synchronized supply-low warning |
| addr | input | ADDR_W | Host byte address |
| ce_n | input | 1 | Active-low chip select |
| oe_n | input | 1 | Active-low output enable |
| we_n | input | 1 | Active-low write enable |
| data_in | input | DATA_W | Host write data |
| data_out | output | DATA_W | Host read data, zero when not driven |
| data_oe | output | 1 | High when the block drives the data bus |
| busy | output | 1 | High during recall or store |

## Verification
Each kind of control-state fault shows up at the ports within a bounded time:

- **Wrong sequencer state:** `busy` is raised at the wrong time, or `data_oe` is high while it should be off. Either shows on the cycle after the faulty transition.
- **Wrong dirty flag:** a store is started or skipped wrongly. This shows one cycle after the supply-low edge, as a `busy` pulse that is present or missing.
- **Wrong transfer counter or step timer:** the length of the `busy` period is wrong. A skipped or repeated address returns wrong bytes on the first reads after the next power cycle. The bench therefore reads back the first, last and interior addresses after each power cycle.

// File: rtl/autostore_pkg.sv
package autostore_pkg;
   typedef enum logic [1:0] {
      ST_OFF    = 2'd0,
      ST_RECALL = 2'd1,
      ST_IDLE   = 2'd2,
      ST_STORE  = 2'd3
   } nv_state_t;
endpackage

// File: rtl/autostore_seq.sv
module autostore_seq
   import autostore_pkg::*;
#(
   parameter int ADDR_W      = 11,
   parameter int CELL_CYCLES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pwr_good,
   input  logic              pwr_low,
   input  logic              oe_n,
   input  logic              host_wr,
   output nv_state_t         state,
   output logic              dirty,
   output logic              busy,
   output logic              host_en,
   output logic [ADDR_W-1:0] xfer_addr,
   output logic              recall_wr,
   output logic              store_wr
);
   localparam int TW = (CELL_CYCLES > 1) ? $clog2(CELL_CYCLES) : 1;

   nv_state_t         nxt;
   logic [ADDR_W-1:0] cnt;
   logic              low_q;
   logic              low_rise;
   logic              last;
   logic              step_done;

   assign low_rise = pwr_low & ~low_q;
   assign last     = (cnt == {ADDR_W{1'b1}});

   // step timer variant chosen by parameter
   generate
      if (CELL_CYCLES == 1) begin : g_single
         assign step_done = 1'b1;
      end else begin : g_timer
         logic [TW-1:0] tcnt;
         assign step_done = (tcnt == TW'(CELL_CYCLES - 1));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                tcnt <= '0;
            else if (state != ST_STORE) tcnt <= '0;
            else if (step_done)        tcnt <= '0;
            else                       tcnt <= tcnt + 1'b1;
         end
      end
   endgenerate

   always_comb begin
      nxt = state;
      case (state)
         ST_OFF:    if (pwr_good) nxt = ST_RECALL;
         ST_RECALL: if (last) nxt = pwr_good ? ST_IDLE : ST_OFF;
         ST_IDLE: begin
            if (low_rise && dirty && oe_n) nxt = ST_STORE;
            else if (!pwr_good)            nxt = ST_OFF;
         end
         ST_STORE:  if (last && step_done) nxt = pwr_good ? ST_IDLE : ST_OFF;
         default:   nxt = ST_OFF;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_OFF;
         cnt   <= '0;
         low_q <= 1'b0;
         dirty <= 1'b0;
      end else begin
         state <= nxt;
         low_q <= pwr_low;
         if (state == ST_RECALL)                   cnt <= cnt + 1'b1;
         else if (state == ST_STORE && step_done)  cnt <= cnt + 1'b1;
         else if (state != ST_STORE)               cnt <= '0;
         if (state == ST_RECALL)                            dirty <= 1'b0;
         else if (state == ST_STORE && last && step_done)   dirty <= 1'b0;
         else if (host_wr)                                  dirty <= 1'b1;
      end
   end

   assign busy      = (state == ST_RECALL) || (state == ST_STORE);
   assign host_en   = (state == ST_IDLE) && pwr_good;
   assign xfer_addr = cnt;
   assign recall_wr = (state == ST_RECALL);
   assign store_wr  = (state == ST_STORE) && step_done;
endmodule

// File: rtl/autostore_mem.sv
module autostore_mem #(
   parameter int ADDR_W = 11,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              host_we,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic [DATA_W-1:0] host_wdata,
   output logic [DATA_W-1:0] host_rdata,
   input  logic [ADDR_W-1:0] xfer_addr,
   input  logic              recall_wr,
   input  logic              store_wr
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] ram    [DEPTH];
   logic [DATA_W-1:0] shadow [DEPTH];

   always_ff @(posedge clk) begin
      if (host_we)        ram[host_addr] <= host_wdata;
      else if (recall_wr) ram[xfer_addr] <= shadow[xfer_addr];
   end

   always_ff @(posedge clk) begin
      if (store_wr) shadow[xfer_addr] <= ram[xfer_addr];
   end

   assign host_rdata = ram[host_addr];
endmodule

// File: rtl/autostore_host.sv
module autostore_host (
   input  logic host_en,
   input  logic ce_n,
   input  logic oe_n,
   input  logic we_n,
   output logic wr_strobe,
   output logic rd_drive
);
   assign wr_strobe = host_en && !ce_n && !we_n;
   assign rd_drive  = host_en && !ce_n && !oe_n && we_n;
endmodule

// File: rtl/autostore_nvram.sv
module autostore_nvram
   import autostore_pkg::*;
#(
   parameter int ADDR_W      = 11,
   parameter int DATA_W      = 8,
   parameter int CELL_CYCLES = 2,
   parameter int STORE_LIMIT = 625000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pwr_good,
   input  logic              pwr_low,
   input  logic [ADDR_W-1:0] addr,
   input  logic              ce_n,
   input  logic              oe_n,
   input  logic              we_n,
   input  logic [DATA_W-1:0] data_in,
   output logic [DATA_W-1:0] data_out,
   output logic              data_oe,
   output logic              busy
);
   localparam int DEPTH      = 1 << ADDR_W;
   localparam int STORE_CYCS = DEPTH * CELL_CYCLES;

   generate
      if (ADDR_W < 1 || ADDR_W > 16) begin : g_bad_addr
         $error("ADDR_W out of range");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("DATA_W must be positive");
      end
      if (CELL_CYCLES < 1) begin : g_bad_cell
         $error("CELL_CYCLES must be positive");
      end
      if (STORE_CYCS > STORE_LIMIT) begin : g_bad_time
         $error("store does not fit in STORE_LIMIT");
      end
   endgenerate

   nv_state_t         state;
   logic              dirty;
   logic              host_en;
   logic              wr_strobe;
   logic              rd_drive;
   logic [ADDR_W-1:0] xfer_addr;
   logic              recall_wr;
   logic              store_wr;
   logic [DATA_W-1:0] rdata;

   autostore_seq #(.ADDR_W(ADDR_W), .CELL_CYCLES(CELL_CYCLES)) u_seq (
      .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .pwr_low(pwr_low),
      .oe_n(oe_n), .host_wr(wr_strobe), .state(state), .dirty(dirty),
      .busy(busy), .host_en(host_en), .xfer_addr(xfer_addr),
      .recall_wr(recall_wr), .store_wr(store_wr)
   );

   autostore_host u_host (
      .host_en(host_en), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
      .wr_strobe(wr_strobe), .rd_drive(rd_drive)
   );

   autostore_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
      .clk(clk), .host_we(wr_strobe), .host_addr(addr), .host_wdata(data_in),
      .host_rdata(rdata), .xfer_addr(xfer_addr), .recall_wr(recall_wr),
      .store_wr(store_wr)
   );

   assign data_oe  = rd_drive;
   assign data_out = rd_drive ? rdata : '0;
endmodule

// File: rtl/autostore_nvram_chk.sv
module autostore_nvram_chk
   import autostore_pkg::*;
#(
   parameter int STORE_LIMIT = 625000
) (
   input logic      clk,
   input logic      rst_n,
   input logic      pwr_good,
   input logic      pwr_low,
   input logic      ce_n,
   input logic      oe_n,
   input logic      we_n,
   input logic      data_oe,
   input logic      busy,
   input nv_state_t st,
   input logic      dirty
);
   int unsigned run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    run <= 0;
      else if (busy) run <= run + 1;
      else           run <= 0;
   end

   assert_hiz_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ce_n || oe_n || !we_n) |-> !data_oe);

   assert_busy_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !data_oe);

   assert_inhibit_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !pwr_good |-> !data_oe);

   assert_store_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
      run <= STORE_LIMIT);

   assert_recall_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_OFF && pwr_good) |=> busy);

   assert_clean_no_store_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE && pwr_good && $rose(pwr_low) && !dirty) |=> !busy);

   assert_oe_blocks_store_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE && pwr_good && $rose(pwr_low) && !oe_n) |=> !busy);
endmodule

bind autostore_nvram autostore_nvram_chk #(.STORE_LIMIT(STORE_LIMIT)) i_chk (
   .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .pwr_low(pwr_low),
   .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .data_oe(data_oe), .busy(busy),
   .st(u_seq.state), .dirty(u_seq.dirty)
);

// File: tb/test_autostore_nvram.sv
module test_autostore_nvram;
   localparam int ADDR_W = 11;
   localparam int DATA_W = 8;
   localparam int CELL   = 2;
   localparam int LIMIT  = 625000;
   localparam int DEPTH  = 1 << ADDR_W;

   typedef struct {
      logic              oe;
      logic [DATA_W-1:0] d;
      string             tag;
   } exp_t;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              pwr_good = 1'b0;
   logic              pwr_low = 1'b0;
   logic [ADDR_W-1:0] addr = '0;
   logic              ce_n = 1'b1;
   logic              oe_n = 1'b1;
   logic              we_n = 1'b1;
   logic [DATA_W-1:0] data_in = '0;
   logic [DATA_W-1:0] data_out;
   logic              data_oe;
   logic              busy;

   int   n_chk = 0;
   int   n_err = 0;
   bit   done = 1'b0;
   exp_t q[$];

   always #2 clk = ~clk;

   autostore_nvram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CELL_CYCLES(CELL),
                     .STORE_LIMIT(LIMIT)) i_autostore_nvram (
      .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .pwr_low(pwr_low),
      .addr(addr), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .data_in(data_in),
      .data_out(data_out), .data_oe(data_oe), .busy(busy)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // monitor: pops one expected bus state per driven cycle
   initial begin
      forever begin
         @(negedge clk);
         if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            if (e.oe)
               check(data_oe === 1'b1 && data_out === e.d, e.tag,
                     {data_oe, data_out}, {1'b1, e.d});
            else
               check(data_oe === 1'b0, e.tag, int'(data_oe), 0);
         end
      end
   end

   task automatic bus(input logic [ADDR_W-1:0] a, input logic c, input logic o,
                      input logic w, input logic eoe, input logic [DATA_W-1:0] ed,
                      input string tag);
      exp_t e;
      @(posedge clk); #1;
      addr = a; ce_n = c; oe_n = o; we_n = w;
      e.oe = eoe; e.d = ed; e.tag = tag;
      q.push_back(e);
   endtask

   task automatic rd(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] ed,
                     input string tag);
      bus(a, 1'b0, 1'b0, 1'b1, 1'b1, ed, tag);
   endtask

   task automatic rd_off(input logic [ADDR_W-1:0] a, input string tag);
      bus(a, 1'b0, 1'b0, 1'b1, 1'b0, '0, tag);
   endtask

   task automatic wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
      @(posedge clk); #1;
      addr = a; data_in = d; ce_n = 1'b0; oe_n = 1'b1; we_n = 1'b0;
      @(posedge clk); #1;
      ce_n = 1'b1; we_n = 1'b1;
   endtask

   task automatic idle_bus();
      @(posedge clk); #1;
      ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
   endtask

   task automatic count_busy(output int n);
      int w;
      w = 0; n = 0;
      while (!busy && w < 8) begin @(negedge clk); w++; end
      while (busy && n < 20000) begin @(negedge clk); n++; end
   endtask

   task automatic expect_quiet(input int k, input string tag);
      bit seen;
      seen = 1'b0;
      for (int i = 0; i < k; i++) begin
         @(negedge clk);
         if (busy) seen = 1'b1;
      end
      check(!seen, tag, int'(seen), 0);
   endtask

   task automatic power_up(input string tag);
      int n;
      fork
         count_busy(n);
         begin @(posedge clk); #1; pwr_good = 1'b1; end
      join
      check(n == DEPTH, tag, n, DEPTH);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_err++;
         $display("FAIL watchdog actual=hung expected=finish");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      int n;
      // R1: reset state
      repeat (3) @(negedge clk);
      check(busy === 1'b0 && data_oe === 1'b0, "R1 in reset", {busy, data_oe}, 0);
      @(posedge clk); #1; rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check(busy === 1'b0 && data_oe === 1'b0, "R1 after reset", {busy, data_oe}, 0);
      rd_off(11'd0, "R8 read while supply low");
      idle_bus();

      // R2: power-up recall length
      power_up("R2 recall length");

      // R6: no write since power-up -> no store
      @(posedge clk); #1; pwr_low = 1'b1;
      expect_quiet(10, "R6 clean no store");
      @(posedge clk); #1; pwr_low = 1'b0;

      // R4/R3: writes and reads
      wr(11'd0, 8'hA5);
      wr(11'd2047, 8'h3C);
      wr(11'd5, 8'h5A);
      wr(11'd1000, 8'hC3);
      rd(11'd0, 8'hA5, "R4 addr0");
      rd(11'd2047, 8'h3C, "R4 addr last");
      rd(11'd5, 8'h5A, "R3 read addr5");
      rd(11'd1000, 8'hC3, "R3 read addr1000");
      bus(11'd5, 1'b0, 1'b1, 1'b1, 1'b0, '0, "R3 oe_n high");
      bus(11'd5, 1'b1, 1'b0, 1'b1, 1'b0, '0, "R3 ce_n high");
      data_in = 8'h5A;
      bus(11'd5, 1'b0, 1'b0, 1'b0, 1'b0, '0, "R3 we_n low");
      idle_bus();

      // R7: oe_n low blocks store
      @(posedge clk); #1; oe_n = 1'b0; pwr_low = 1'b1;
      expect_quiet(10, "R7 oe_n low no store");
      @(posedge clk); #1; oe_n = 1'b1; pwr_low = 1'b0;
      repeat (2) @(posedge clk);

      // R5/R9/R11: store with writes attempted and a supply dip inside it
      fork
         count_busy(n);
         begin
            @(posedge clk); #1; pwr_low = 1'b1;
            repeat (3) @(posedge clk);
            wr(11'd5, 8'hEE);
            rd_off(11'd5, "R9 read during store");
            idle_bus();
            @(posedge clk); #1; pwr_good = 1'b0;
            repeat (10) @(posedge clk);
            #1; pwr_good = 1'b1;
         end
      join
      check(n == DEPTH * CELL, "R5 store length", n, DEPTH * CELL);
      check(n <= LIMIT, "R5 store within limit", n, LIMIT);
      expect_quiet(30, "R11 no recall after dip");
      rd(11'd5, 8'h5A, "R9 write during store ignored");
      rd(11'd0, 8'hA5, "R11 data kept after store");
      idle_bus();

      // R10: store cleared dirty
      @(posedge clk); #1; pwr_low = 1'b0;
      repeat (2) @(posedge clk);
      #1; pwr_low = 1'b1;
      expect_quiet(10, "R10 no second store");
      @(posedge clk); #1; pwr_low = 1'b0;

      // R8/R2: unsaved write, power cycle, recall restores shadow
      wr(11'd0, 8'h11);
      rd(11'd0, 8'h11, "R4 overwrite addr0");
      idle_bus();
      @(posedge clk); #1; pwr_good = 1'b0;
      repeat (4) @(posedge clk);
      rd_off(11'd0, "R8 read while inhibited");
      idle_bus();
      power_up("R2 second recall length");
      rd(11'd0, 8'hA5, "R2 recall addr0");
      rd(11'd2047, 8'h3C, "R2 recall last");
      rd(11'd5, 8'h5A, "R2 recall addr5");
      rd(11'd1000, 8'hC3, "R2 recall addr1000");
      idle_bus();

      // R12: recall cleared dirty
      @(posedge clk); #1; pwr_low = 1'b1;
      expect_quiet(10, "R12 no store after recall");

      repeat (3) @(posedge clk);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule